// File: doc/BRIEF.md
# Tagged Word Load/Store Checker

This block sits between a 32-bit memory port and an integer register file in which each register carries one extra type bit. On a load it attaches that extra bit to the incoming word, taking its value from a per-access input that says whether the addressed region holds typed values. On a store it compares the register's extra bit with the region and refuses the write on a mismatch. The extra bit never travels to memory on an ordinary store. A spill to the stack is the exception: the spilled word carries its extra bit out on a side output, and the matching fill brings it back.

When the extra bit is set, the low bits of the word carry a second level of type. A set bit 0 marks a small integer held in bits 31:1. Low bits `10` mark a character. Low bits `00` mark an object reference. The block reports this class for the source operand in the same cycle. It performs the two user-level conversions between small integers and raw words, and a raw add. Any attempt to change an object reference, and any conversion that is illegal or overflows, becomes a registered trap with a cause code. A trapping operation writes neither the destination register nor memory.

Top module: `tagword_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `destWe`, `memWe`, `trapValid`, `destTag` and `memWrTag` are 0 and `trapCause` is 0.
- R2: A load (`opCode`=1) produces, one clock later, `destWe`=1, `destData`=`memRdData` and `destTag`=`regionTagged`, with no trap.
- R3: `srcClass` follows the source operand in the same cycle. It is 0 (raw) when `srcTag`=0. When `srcTag`=1 it is 1 (small integer) if bit 0 is 1, 2 (character) if bits 1:0 are `10`, and 3 (object reference) if bits 1:0 are `00`.
- R4: A store (`opCode`=2) whose `srcTag` equals `regionTagged` gives, one clock later, `memWe`=1, `memWrData`=`srcData` and `memWrTag`=0.
- R5: A store whose `srcTag` differs from `regionTagged` gives, one clock later, `trapValid`=1 with `trapCause`=1, and `memWe`=0.
- R6: A spill (`opCode`=3) writes `srcData` with `memWrTag`=`srcTag` whatever the region, without a check. A fill (`opCode`=4) gives `destWe`=1, `destData`=`memRdData` and `destTag`=`memRdTag`.
- R7: Untag (`opCode`=5) of a small integer gives `destData` = the source shifted right by one with sign fill, and `destTag`=0.
- R8: Retag (`opCode`=6) of a raw word whose bits 31 and 30 are equal gives `destData` = {source[30:0], 1} with `destTag`=1. If bits 31 and 30 differ, it raises `trapCause`=2 and `destWe`=0.
- R9: Untag, retag or add whose source is an object reference raises `trapCause`=3 with `destWe`=0 and `memWe`=0.
- R10: Untag of a raw word or character, retag of any tagged non-reference, and add of any tagged non-reference raise `trapCause`=4 with `destWe`=0.
- R11: Add (`opCode`=7) of a raw source gives `destData` = `srcData`+`addData` modulo 2^32 with `destTag`=0.
- R12: Each result or trap lasts one cycle only, so a no-op (`opCode`=0) leaves every strobe at 0 on the next cycle. `trapValid` is never high together with `destWe` or `memWe`. `trapCause` is 0 whenever `trapValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | 0 no-op, 1 load, 2 store, 3 spill, 4 fill, 5 untag, 6 retag, 7 add |
| srcData | input | 32 | Source register payload |
| srcTag | input | 1 | Source register extra type bit |
| addData | input | 32 | Second operand of the raw add |
| regionTagged | input | 1 | Accessed region holds typed words |
| memRdData | input | 32 | Word returned by memory for load or fill |
| memRdTag | input | 1 | Extra bit returned with a filled stack word |
| srcClass | output | 2 | Class of the source operand (same cycle) |
| destWe | output | 1 | Destination register write strobe |
| destData | output | 32 | Destination payload |
| destTag | output | 1 | Destination extra type bit |
| memWe | output | 1 | Memory write strobe |
| memWrData | output | 32 | Memory write word |
| memWrTag | output | 1 | Extra bit carried with a spilled word |
| trapValid | output | 1 | Supervisor trap request, one cycle |
| trapCause | output | 3 | 1 store type mismatch, 2 overflow, 3 object reference altered, 4 wrong type |

## Verification
The hardest case to reach from the ports is the overflow edge of retag. Only raw words whose top two bits differ must trap. Values on either side of that edge (`3FFFFFFF`, `40000000`, `BFFFFFFF`, `C0000000`) have to meet every opcode, both tag values and both region settings. The stimulus therefore sweeps a list of boundary bases combined with all four low-bit patterns across the full opcode, tag and region space. A no-op follows every vector, so that a trap or write that stays high for a second cycle shows up.

// File: rtl/tagword_pkg.sv
package tagword_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_SPILL = 3'd3,
    OP_FILL  = 3'd4,
    OP_UNTAG = 3'd5,
    OP_RETAG = 3'd6,
    OP_ADD   = 3'd7
  } wordOp_t;

  typedef enum logic [1:0] {
    CLS_RAW      = 2'd0,
    CLS_SMALLINT = 2'd1,
    CLS_CHAR     = 2'd2,
    CLS_OOP      = 2'd3
  } wordClass_t;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_STORE_TAG = 3'd1,
    CAUSE_OVERFLOW  = 3'd2,
    CAUSE_OOP_ALTER = 3'd3,
    CAUSE_TYPE      = 3'd4
  } trapCause_t;

  typedef enum logic [2:0] {
    SEL_MEM   = 3'd0,
    SEL_FILL  = 3'd1,
    SEL_UNTAG = 3'd2,
    SEL_RETAG = 3'd3,
    SEL_ADD   = 3'd4
  } resultSel_t;

  typedef struct packed {
    logic       destWe;
    logic       memWe;
    logic       keepTag;
    logic       trap;
    trapCause_t cause;
    resultSel_t sel;
  } ctrlStrobes_t;

endpackage

// File: rtl/tagword_ctrl.sv
module tagword_ctrl
  import tagword_pkg::*;
(
  input  logic [2:0]   opCode,
  input  wordClass_t   srcClass,
  input  logic         srcTag,
  input  logic         regionTagged,
  input  logic         fitsSmall,
  output ctrlStrobes_t strobes
);

  wordOp_t op;
  assign op = wordOp_t'(opCode);

  // raise a trap and suppress every write
  function automatic ctrlStrobes_t trapWith(input trapCause_t c);
    ctrlStrobes_t t;
    t = '0;
    t.trap = 1'b1;
    t.cause = c;
    return t;
  endfunction

  always_comb begin
    strobes = '0;
    unique case (op)
      OP_LOAD: begin
        strobes.destWe = 1'b1;
        strobes.sel = SEL_MEM;
      end
      OP_STORE: begin
        if (srcTag == regionTagged) strobes.memWe = 1'b1;
        else strobes = trapWith(CAUSE_STORE_TAG);
      end
      OP_SPILL: begin
        strobes.memWe = 1'b1;
        strobes.keepTag = 1'b1;
      end
      OP_FILL: begin
        strobes.destWe = 1'b1;
        strobes.sel = SEL_FILL;
      end
      OP_UNTAG: begin
        if (srcClass == CLS_OOP) strobes = trapWith(CAUSE_OOP_ALTER);
        else if (srcClass != CLS_SMALLINT) strobes = trapWith(CAUSE_TYPE);
        else begin
          strobes.destWe = 1'b1;
          strobes.sel = SEL_UNTAG;
        end
      end
      OP_RETAG: begin
        if (srcClass == CLS_OOP) strobes = trapWith(CAUSE_OOP_ALTER);
        else if (srcClass != CLS_RAW) strobes = trapWith(CAUSE_TYPE);
        else if (!fitsSmall) strobes = trapWith(CAUSE_OVERFLOW);
        else begin
          strobes.destWe = 1'b1;
          strobes.sel = SEL_RETAG;
        end
      end
      OP_ADD: begin
        if (srcClass == CLS_OOP) strobes = trapWith(CAUSE_OOP_ALTER);
        else if (srcClass != CLS_RAW) strobes = trapWith(CAUSE_TYPE);
        else begin
          strobes.destWe = 1'b1;
          strobes.sel = SEL_ADD;
        end
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/tagword_datapath.sv
module tagword_datapath
  import tagword_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] srcData,
  input  logic              srcTag,
  input  logic [WORD_W-1:0] addData,
  input  logic              regionTagged,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              memRdTag,
  output wordClass_t        srcClass,
  output logic              fitsSmall,
  output logic              destWe,
  output logic [WORD_W-1:0] destData,
  output logic              destTag,
  output logic              memWe,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWrTag,
  output logic              trapValid,
  output logic [2:0]        trapCause
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] resData;
  logic              resTag;

  // second-level type from the two low bits, only under a set extra bit
  always_comb begin
    if (!srcTag) srcClass = CLS_RAW;
    else if (srcData[0]) srcClass = CLS_SMALLINT;
    else if (srcData[1]) srcClass = CLS_CHAR;
    else srcClass = CLS_OOP;
  end

  // a raw word fits the small-integer range when its top two bits agree
  assign fitsSmall = (srcData[MSB] == srcData[MSB-1]);

  always_comb begin
    resData = memRdData;
    resTag  = regionTagged;
    case (strobes.sel)
      SEL_MEM:   begin resData = memRdData; resTag = regionTagged; end
      SEL_FILL:  begin resData = memRdData; resTag = memRdTag; end
      SEL_UNTAG: begin resData = {srcData[MSB], srcData[MSB:1]}; resTag = 1'b0; end
      SEL_RETAG: begin resData = {srcData[MSB-1:0], 1'b1}; resTag = 1'b1; end
      SEL_ADD:   begin resData = srcData + addData; resTag = 1'b0; end
      default:   begin resData = memRdData; resTag = regionTagged; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destWe    <= 1'b0;
      destData  <= '0;
      destTag   <= 1'b0;
      memWe     <= 1'b0;
      memWrData <= '0;
      memWrTag  <= 1'b0;
      trapValid <= 1'b0;
      trapCause <= 3'd0;
    end else begin
      destWe    <= strobes.destWe;
      destData  <= strobes.destWe ? resData : '0;
      destTag   <= strobes.destWe & resTag;
      memWe     <= strobes.memWe;
      memWrData <= strobes.memWe ? srcData : '0;
      memWrTag  <= strobes.memWe & strobes.keepTag & srcTag;
      trapValid <= strobes.trap;
      trapCause <= strobes.trap ? strobes.cause : CAUSE_NONE;
    end
  end

endmodule

// File: rtl/tagword_unit.sv
module tagword_unit
  import tagword_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [WORD_W-1:0] srcData,
  input  logic              srcTag,
  input  logic [WORD_W-1:0] addData,
  input  logic              regionTagged,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              memRdTag,
  output logic [1:0]        srcClass,
  output logic              destWe,
  output logic [WORD_W-1:0] destData,
  output logic              destTag,
  output logic              memWe,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWrTag,
  output logic              trapValid,
  output logic [2:0]        trapCause
);

  ctrlStrobes_t strobes;
  wordClass_t   cls;
  logic         fitsSmall;

  assign srcClass = cls;

  tagword_ctrl i_ctrl (
    .opCode      (opCode),
    .srcClass    (cls),
    .srcTag      (srcTag),
    .regionTagged(regionTagged),
    .fitsSmall   (fitsSmall),
    .strobes     (strobes)
  );

  tagword_datapath #(.WORD_W(WORD_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .srcData     (srcData),
    .srcTag      (srcTag),
    .addData     (addData),
    .regionTagged(regionTagged),
    .memRdData   (memRdData),
    .memRdTag    (memRdTag),
    .srcClass    (cls),
    .fitsSmall   (fitsSmall),
    .destWe      (destWe),
    .destData    (destData),
    .destTag     (destTag),
    .memWe       (memWe),
    .memWrData   (memWrData),
    .memWrTag    (memWrTag),
    .trapValid   (trapValid),
    .trapCause   (trapCause)
  );

endmodule

// File: rtl/tagword_checker.sv
module tagword_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opCode,
  input logic [WORD_W-1:0] srcData,
  input logic              srcTag,
  input logic [WORD_W-1:0] addData,
  input logic              regionTagged,
  input logic [WORD_W-1:0] memRdData,
  input logic              memRdTag,
  input logic [1:0]        srcClass,
  input logic              destWe,
  input logic [WORD_W-1:0] destData,
  input logic              destTag,
  input logic              memWe,
  input logic [WORD_W-1:0] memWrData,
  input logic              memWrTag,
  input logic              trapValid,
  input logic [2:0]        trapCause
);

  p_load_tag_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd1)
      |-> (destWe && destTag == $past(regionTagged) && destData == $past(memRdData)));

  p_raw_class_r3: assert property (@(posedge clk) disable iff (!rstN)
    !srcTag |-> srcClass == 2'd0);

  p_store_mismatch_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd2 && $past(srcTag) != $past(regionTagged))
      |-> (trapValid && trapCause == 3'd1 && !memWe));

  p_spill_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd3)
      |-> (memWe && memWrTag == $past(srcTag) && memWrData == $past(srcData)));

  p_retag_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) == 3'd6 && !$past(srcTag)
      && $past(srcData[WORD_W-1]) != $past(srcData[WORD_W-2]))
      |-> (trapValid && trapCause == 3'd2 && !destWe));

  p_oop_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opCode) >= 3'd5 && $past(srcTag) && $past(srcData[1:0]) == 2'b00)
      |-> (trapValid && trapCause == 3'd3 && !destWe && !memWe));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (!destWe && !memWe));

  p_cause_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> trapCause == 3'd0);

endmodule

bind tagword_unit tagword_checker #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_tagword_unit.sv
`timescale 1ns/1ps
module test_tagword_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [31:0] srcData = '0;
  logic        srcTag = 1'b0;
  logic [31:0] addData = '0;
  logic        regionTagged = 1'b0;
  logic [31:0] memRdData = '0;
  logic        memRdTag = 1'b0;
  logic [1:0]  srcClass;
  logic        destWe, destTag, memWe, memWrTag, trapValid;
  logic [31:0] destData, memWrData;
  logic [2:0]  trapCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tagword_unit i_tagword_unit (
    .clk(clk), .rstN(rstN), .opCode(opCode), .srcData(srcData), .srcTag(srcTag),
    .addData(addData), .regionTagged(regionTagged), .memRdData(memRdData),
    .memRdTag(memRdTag), .srcClass(srcClass), .destWe(destWe), .destData(destData),
    .destTag(destTag), .memWe(memWe), .memWrData(memWrData), .memWrTag(memWrTag),
    .trapValid(trapValid), .trapCause(trapCause)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // all strobes idle: reset state (R1) or the cycle after a no-op (R12)
  task automatic checkIdle(input string req);
    check(req, "destWe", {31'd0, destWe}, 32'd0);
    check(req, "memWe", {31'd0, memWe}, 32'd0);
    check(req, "trapValid", {31'd0, trapValid}, 32'd0);
    check(req, "trapCause", {29'd0, trapCause}, 32'd0);
    check(req, "destTag", {31'd0, destTag}, 32'd0);
    check(req, "memWrTag", {31'd0, memWrTag}, 32'd0);
  endtask

  function automatic logic [31:0] baseWord(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFC;
      2: return 32'h8000_0000;
      3: return 32'h3FFF_FFFC;
      4: return 32'h4000_0000;
      5: return 32'hC000_0000;
      6: return 32'hBFFF_FFFC;
      7: return 32'h1234_5678;
      8: return 32'hFFFF_FFFC;
      default: return 32'hA5A5_A5A4;
    endcase
  endfunction

  task automatic runVector(input logic [2:0] op, input logic t, input logic reg_t,
                           input logic [31:0] d, input logic [31:0] a,
                           input logic [31:0] m, input logic mt);
    logic [1:0]  eCls;
    logic        eDestWe, eMemWe, eTrap, eDestTag, eMemTag;
    logic [31:0] eDest, eMem;
    logic [2:0]  eCause;
    string       req;

    @(negedge clk);
    opCode = op; srcTag = t; regionTagged = reg_t; srcData = d;
    addData = a; memRdData = m; memRdTag = mt;
    #0.5;
    // R3 class codes: 0 raw, 1 small integer, 2 character, 3 reference
    eCls = !t ? 2'd0 : d[0] ? 2'd1 : d[1] ? 2'd2 : 2'd3;
    check("R3", "srcClass", {30'd0, srcClass}, {30'd0, eCls});

    eDestWe = 0; eMemWe = 0; eTrap = 0; eCause = 3'd0;
    eDestTag = 0; eMemTag = 0; eDest = '0; eMem = '0; req = "R12";
    case (op)
      3'd1: begin req = "R2"; eDestWe = 1; eDest = m; eDestTag = reg_t; end
      3'd2: begin
        if (t == reg_t) begin req = "R4"; eMemWe = 1; eMem = d; end
        else begin req = "R5"; eTrap = 1; eCause = 3'd1; end
      end
      3'd3: begin req = "R6"; eMemWe = 1; eMem = d; eMemTag = t; end
      3'd4: begin req = "R6"; eDestWe = 1; eDest = m; eDestTag = mt; end
      3'd5: begin
        if (eCls == 2'd3) begin req = "R9"; eTrap = 1; eCause = 3'd3; end
        else if (eCls != 2'd1) begin req = "R10"; eTrap = 1; eCause = 3'd4; end
        else begin req = "R7"; eDestWe = 1; eDest = $unsigned($signed(d) >>> 1); end
      end
      3'd6: begin
        if (eCls == 2'd3) begin req = "R9"; eTrap = 1; eCause = 3'd3; end
        else if (eCls != 2'd0) begin req = "R10"; eTrap = 1; eCause = 3'd4; end
        else if (d[31] != d[30]) begin req = "R8"; eTrap = 1; eCause = 3'd2; end
        else begin req = "R8"; eDestWe = 1; eDest = d * 2 + 1; eDestTag = 1; end
      end
      3'd7: begin
        if (eCls == 2'd3) begin req = "R9"; eTrap = 1; eCause = 3'd3; end
        else if (eCls != 2'd0) begin req = "R10"; eTrap = 1; eCause = 3'd4; end
        else begin req = "R11"; eDestWe = 1; eDest = d + a; end
      end
      default: req = "R12";
    endcase

    @(posedge clk);
    #0.5;
    check(req, "destWe", {31'd0, destWe}, {31'd0, eDestWe});
    check(req, "memWe", {31'd0, memWe}, {31'd0, eMemWe});
    check(req, "trapValid", {31'd0, trapValid}, {31'd0, eTrap});
    check(req, "trapCause", {29'd0, trapCause}, {29'd0, eCause});
    if (eDestWe) begin
      check(req, "destData", destData, eDest);
      check(req, "destTag", {31'd0, destTag}, {31'd0, eDestTag});
    end
    if (eMemWe) begin
      check(req, "memWrData", memWrData, eMem);
      check(req, "memWrTag", {31'd0, memWrTag}, {31'd0, eMemTag});
    end

    // follow with a no-op: every strobe must drop (R12)
    @(negedge clk);
    opCode = 3'd0;
    @(posedge clk);
    #0.5;
    checkIdle("R12");
  endtask

  initial begin
    #1;
    checkIdle("R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #0.5;
    checkIdle("R1");

    for (int op = 0; op < 8; op++)
      for (int t = 0; t < 2; t++)
        for (int rg = 0; rg < 2; rg++)
          for (int b = 0; b < 10; b++)
            for (int lo = 0; lo < 4; lo++)
              runVector(3'(op), t[0], rg[0], baseWord(b) | 32'(lo),
                        32'h0001_0003 * 32'(b + 1) + 32'(lo << 30),
                        32'h5A5A_0000 ^ 32'(b * 4 + lo), lo[0] ^ b[0]);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule